// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Register File

This block is the software-visible register file of an I/O interrupt controller with 24 input pins. Software reaches every register through a single pair of locations: it first writes a register index into a select register, then reads or writes the chosen 32-bit register through a data window. Behind the window sit a controller identifier, a fixed version word, an arbitration word that is always zero, and one 64-bit redirection entry per input pin, each entry split into a low and a high 32-bit half at two consecutive indices.

All redirection entries are presented side by side to the delivery logic, which owns the remote-IRR status bit of each entry through per-pin set and clear strobes. Whenever software rewrites any half of an entry, the block raises a one-cycle table-changed pulse so that the delivery logic can rescan its pending requests. The delivery itself is outside this block.

Top module: `irq_redir_regfile`

## Requirements
- R1: The select register sits at byte offset 0x00 of the low 8 address bits; a write of any size stores wdata[7:0], and a read of any size returns the stored index zero-extended to 32 bits.
- R2: Byte offsets other than 0x00 and 0x10 read as zero, and writes to them change no register.
- R3: The data window at offset 0x10 is honoured only when the transfer size equals 4 bytes; any other size reads zero and discards the write.
- R4: Index 0x00 is the identifier register: the identifier reads in bits 31:24 with all other bits zero, and a write stores only wdata[31:24].
- R5: Index 0x01 reads the constant 0x0017_0011 (version 0x11 in bits 7:0, highest entry number 23 in bits 23:16) and index 0x02 reads zero; writes to either are ignored.
- R6: Entry n is at index 0x10+2n (bits 31:0) and 0x11+2n (bits 63:32); a write replaces only the addressed half, and entry n appears on entries_o bits 64n+63 down to 64n.
- R7: Indices 0x03 to 0x0F and 0x40 to 0xFF read zero and ignore writes.
- R8: After reset every entry equals 0x0000_0000_0001_0000 (mask bit 16 set), the identifier and the select register are zero, and tbl_chg_o is low.
- R9: A honoured window write to any entry half drives tbl_chg_o high for exactly the one cycle after the write edge; other writes leave it low.
- R10: Bit 14 of every entry (remote-IRR) keeps its value on software writes; rirr_set[n] sets it and rirr_clr[n] clears it at the next edge, and set wins when both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, committed at the clock edge |
| bus_rd | input | 1 | Read strobe, data returned combinationally |
| bus_addr | input | 8 | Low byte of the access address |
| bus_size | input | 3 | Transfer size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when bus_rd is low |
| rirr_set | input | 24 | Per-pin remote-IRR set strobes from delivery logic |
| rirr_clr | input | 24 | Per-pin remote-IRR clear strobes from delivery logic |
| entries_o | output | 1536 | All redirection entries, entry n in bits 64n+63:64n |
| tbl_chg_o | output | 1 | One-cycle pulse after any entry half is written |

## Verification
The hardest state to reach from the ports is a remote-IRR bit that is set while software rewrites the same low half, since software alone can never set that bit. The bench first raises the bit through a set strobe, then writes the low half with bit 14 both clear and set and reads it back through the window, and finally drives set and clear in the same cycle to pin down their priority. Window accesses with a wrong transfer size are interleaved with good ones so that a discarded write is followed by a read that would expose it.

// File: rtl/irr_pkg.sv
package irr_pkg;

  localparam logic [7:0]  OFF_SEL   = 8'h00;
  localparam logic [7:0]  OFF_WIN   = 8'h10;
  localparam logic [2:0]  WIN_SIZE  = 3'd4;
  localparam logic [7:0]  IDX_ID    = 8'h00;
  localparam logic [7:0]  IDX_VER   = 8'h01;
  localparam logic [7:0]  IDX_ARB   = 8'h02;
  localparam logic [7:0]  IDX_TBL   = 8'h10;
  localparam logic [7:0]  VER_CODE  = 8'h11;
  localparam int          BIT_RIRR  = 14;
  localparam int          BIT_MASK  = 16;
  localparam logic [63:0] ENT_RESET = 64'h0000_0000_0001_0000;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_ID,
    TGT_VER,
    TGT_ARB,
    TGT_ENTRY
  } tgt_e;

endpackage

// File: rtl/irr_rst_sync.sv
module irr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/irr_decode.sv
module irr_decode
  import irr_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic [7:0]       addr,
  input  logic [2:0]       size,
  input  logic [7:0]       sel,
  output logic             hit_sel,
  output logic             win_ok,
  output tgt_e             tgt,
  output logic [IDX_W-1:0] ent_idx,
  output logic             ent_hi
);

  localparam logic [7:0] TBL_SPAN = 8'(2 * NUM_PINS);

  logic [7:0] tbl_off;
  logic       tbl_hit;

  assign hit_sel = (addr == OFF_SEL);
  assign win_ok  = (addr == OFF_WIN) && (size == WIN_SIZE);

  assign tbl_off = sel - IDX_TBL;
  assign tbl_hit = (sel >= IDX_TBL) && (tbl_off < TBL_SPAN);
  assign ent_idx = IDX_W'(tbl_off >> 1);
  assign ent_hi  = tbl_off[0];

  always_comb begin
    tgt = TGT_NONE;
    if (sel == IDX_ID)       tgt = TGT_ID;
    else if (sel == IDX_VER) tgt = TGT_VER;
    else if (sel == IDX_ARB) tgt = TGT_ARB;
    else if (tbl_hit)        tgt = TGT_ENTRY;
  end

endmodule

// File: rtl/irr_entry.sv
module irr_entry
  import irr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        rirr_set,
  input  logic        rirr_clr,
  output logic [63:0] entry_o
);

  logic [63:0] ent_q;
  logic [63:0] ent_d;
  logic        ent_en;

  always_comb begin
    ent_d = ent_q;
    if (wr_lo) begin
      ent_d[31:0]     = wdata;
      ent_d[BIT_RIRR] = ent_q[BIT_RIRR];
    end
    if (wr_hi) ent_d[63:32] = wdata;
    if (rirr_set)      ent_d[BIT_RIRR] = 1'b1;
    else if (rirr_clr) ent_d[BIT_RIRR] = 1'b0;
  end

  assign ent_en = wr_lo | wr_hi | rirr_set | rirr_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ent_q <= ENT_RESET;
    else if (ent_en) ent_q <= ent_d;
  end

  assign entry_o = ent_q;

  // R10: without a strobe the remote-IRR bit never moves
  assert_rirr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rirr_set && !rirr_clr) |=> $stable(entry_o[BIT_RIRR]));

  // R10: a set strobe always lands, even against a clear
  assert_rirr_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rirr_set |=> entry_o[BIT_RIRR]);

  // R6: writing the high half leaves the low half untouched
  assert_hi_keeps_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo && !rirr_set && !rirr_clr) |=> $stable(entry_o[31:0]));

endmodule

// File: rtl/irr_read_mux.sv
module irr_read_mux
  import irr_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic             rd,
  input  logic             hit_sel,
  input  logic             win_ok,
  input  tgt_e             tgt,
  input  logic [IDX_W-1:0] ent_idx,
  input  logic             ent_hi,
  input  logic [7:0]       sel,
  input  logic [7:0]       id,
  input  logic [63:0]      ent_i [NUM_PINS],
  output logic [31:0]      rdata
);

  localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VER_CODE};

  logic [63:0] ent_sel;

  always_comb begin
    ent_sel = '0;
    for (int n = 0; n < NUM_PINS; n++) begin
      if (ent_idx == IDX_W'(n)) ent_sel = ent_i[n];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (hit_sel) begin
        rdata = {24'h0, sel};
      end else if (win_ok) begin
        unique case (tgt)
          TGT_ID:    rdata = {id, 24'h0};
          TGT_VER:   rdata = VER_WORD;
          TGT_ARB:   rdata = '0;
          TGT_ENTRY: rdata = ent_hi ? ent_sel[63:32] : ent_sel[31:0];
          default:   rdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/irq_redir_regfile.sv
module irq_redir_regfile
  import irr_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [7:0]               bus_addr,
  input  logic [2:0]               bus_size,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic [NUM_PINS-1:0]      rirr_set,
  input  logic [NUM_PINS-1:0]      rirr_clr,
  output logic [NUM_PINS*64-1:0]   entries_o,
  output logic                     tbl_chg_o
);

  localparam int IDX_W = $clog2(NUM_PINS);

  logic             rst_ni;
  logic [7:0]       sel_q, sel_d;
  logic [7:0]       id_q, id_d;
  logic             chg_q, chg_d;
  logic             hit_sel, win_ok, ent_hi;
  tgt_e             tgt;
  logic [IDX_W-1:0] ent_idx;
  logic             sel_we, id_we, ent_we;
  logic [63:0]      ent_arr [NUM_PINS];

  irr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ni)
  );

  irr_decode #(.NUM_PINS(NUM_PINS)) u_dec (
    .addr    (bus_addr),
    .size    (bus_size),
    .sel     (sel_q),
    .hit_sel (hit_sel),
    .win_ok  (win_ok),
    .tgt     (tgt),
    .ent_idx (ent_idx),
    .ent_hi  (ent_hi)
  );

  assign sel_we = bus_wr && hit_sel;
  assign id_we  = bus_wr && win_ok && (tgt == TGT_ID);
  assign ent_we = bus_wr && win_ok && (tgt == TGT_ENTRY);

  always_comb begin
    sel_d = sel_we ? bus_wdata[7:0]   : sel_q;
    id_d  = id_we  ? bus_wdata[31:24] : id_q;
    chg_d = ent_we;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      id_q  <= '0;
      chg_q <= 1'b0;
    end else begin
      if (sel_we) sel_q <= sel_d;
      if (id_we)  id_q  <= id_d;
      chg_q <= chg_d;
    end
  end

  generate
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_ent
      logic hit_n;
      assign hit_n = ent_we && (ent_idx == IDX_W'(n));
      irr_entry u_ent (
        .clk      (clk),
        .rst_n    (rst_ni),
        .wr_lo    (hit_n && !ent_hi),
        .wr_hi    (hit_n && ent_hi),
        .wdata    (bus_wdata),
        .rirr_set (rirr_set[n]),
        .rirr_clr (rirr_clr[n]),
        .entry_o  (ent_arr[n])
      );
      assign entries_o[64*n +: 64] = ent_arr[n];
    end
  endgenerate

  irr_read_mux #(.NUM_PINS(NUM_PINS)) u_mux (
    .rd      (bus_rd),
    .hit_sel (hit_sel),
    .win_ok  (win_ok),
    .tgt     (tgt),
    .ent_idx (ent_idx),
    .ent_hi  (ent_hi),
    .sel     (sel_q),
    .id      (id_q),
    .ent_i   (ent_arr),
    .rdata   (bus_rdata)
  );

  assign tbl_chg_o = chg_q;

  // R9: the pulse only follows a sized window write
  assert_chg_src_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    tbl_chg_o |-> $past(bus_wr && bus_addr == OFF_WIN && bus_size == WIN_SIZE));

  // R3: a window read of the wrong size returns zero
  assert_size_gate_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_rd && bus_addr == OFF_WIN && bus_size != WIN_SIZE) |-> (bus_rdata == 32'h0));

  // R2: unmapped offsets read zero
  assert_unmapped_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_rd && bus_addr != OFF_SEL && bus_addr != OFF_WIN) |-> (bus_rdata == 32'h0));

  // R4: identifier reads carry nothing below bit 24
  assert_id_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_rd && bus_addr == OFF_WIN && bus_size == WIN_SIZE && sel_q == IDX_ID)
      |-> (bus_rdata[23:0] == 24'h0));

endmodule

// File: tb/irq_redir_regfile_bench.sv
`timescale 1ns/1ps
module irq_redir_regfile_bench;

  localparam int NP = 24;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_wr, bus_rd;
  logic [7:0]        bus_addr;
  logic [2:0]        bus_size;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic [NP-1:0]     rirr_set, rirr_clr;
  logic [NP*64-1:0]  entries_o;
  logic              tbl_chg_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  irq_redir_regfile #(.NUM_PINS(NP)) u_irq_redir_regfile (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rirr_set(rirr_set), .rirr_clr(rirr_clr),
    .entries_o(entries_o), .tbl_chg_o(tbl_chg_o)
  );

  typedef struct packed {
    logic        is_rd;
    logic [7:0]  addr;
    logic [2:0]  size;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 3'd1, 32'h0000_0001, 32'h0, 8'd1},  // R1 select=1
    '{1'b1, 8'h00, 3'd1, 32'h0,         32'h0000_0001, 8'd1},
    '{1'b1, 8'h10, 3'd4, 32'h0,         32'h0017_0011, 8'd5},  // R5 version
    '{1'b0, 8'h10, 3'd4, 32'hFFFF_FFFF, 32'h0, 8'd5},
    '{1'b1, 8'h10, 3'd4, 32'h0,         32'h0017_0011, 8'd5},
    '{1'b0, 8'h00, 3'd4, 32'hFFFF_FF00, 32'h0, 8'd1},          // R1 only low byte kept
    '{1'b1, 8'h00, 3'd4, 32'h0,         32'h0000_0000, 8'd1},
    '{1'b0, 8'h10, 3'd4, 32'hA512_3456, 32'h0, 8'd4},          // R4 id
    '{1'b1, 8'h10, 3'd4, 32'h0,         32'hA500_0000, 8'd4},
    '{1'b1, 8'h10, 3'd2, 32'h0,         32'h0, 8'd3},          // R3 size 2 read
    '{1'b0, 8'h10, 3'd2, 32'h1100_0000, 32'h0, 8'd3},
    '{1'b0, 8'h10, 3'd1, 32'h2200_0000, 32'h0, 8'd3},
    '{1'b1, 8'h10, 3'd4, 32'h0,         32'hA500_0000, 8'd3},
    '{1'b0, 8'h00, 3'd4, 32'h0000_0002, 32'h0, 8'd5},          // R5 arbitration
    '{1'b0, 8'h10, 3'd4, 32'hFFFF_FFFF, 32'h0, 8'd5},
    '{1'b1, 8'h10, 3'd4, 32'h0,         32'h0, 8'd5},
    '{1'b0, 8'h00, 3'd4, 32'h0000_0010, 32'h0, 8'd8},          // entry 0 low
    '{1'b1, 8'h10, 3'd4, 32'h0,         32'h0001_0000, 8'd8},  // R8
    '{1'b0, 8'h10, 3'd4, 32'h0000_4031, 32'h0, 8'd10},
    '{1'b1, 8'h10, 3'd4, 32'h0,         32'h0000_0031, 8'd10}, // R10 bit14 kept
    '{1'b0, 8'h00, 3'd4, 32'h0000_0011, 32'h0, 8'd6},
    '{1'b0, 8'h10, 3'd4, 32'hDEAD_BEEF, 32'h0, 8'd6},
    '{1'b1, 8'h10, 3'd4, 32'h0,         32'hDEAD_BEEF, 8'd6},  // R6
    '{1'b0, 8'h00, 3'd4, 32'h0000_0010, 32'h0, 8'd6},
    '{1'b1, 8'h10, 3'd4, 32'h0,         32'h0000_0031, 8'd6},
    '{1'b0, 8'h00, 3'd4, 32'h0000_003F, 32'h0, 8'd6},          // entry 23 high
    '{1'b0, 8'h10, 3'd4, 32'h1200_0000, 32'h0, 8'd6},
    '{1'b1, 8'h10, 3'd4, 32'h0,         32'h1200_0000, 8'd6},
    '{1'b0, 8'h00, 3'd4, 32'h0000_0040, 32'h0, 8'd7},          // R7 past table
    '{1'b0, 8'h10, 3'd4, 32'hFFFF_FFFF, 32'h0, 8'd7},
    '{1'b1, 8'h10, 3'd4, 32'h0,         32'h0, 8'd7},
    '{1'b0, 8'h00, 3'd4, 32'h0000_0005, 32'h0, 8'd7},
    '{1'b1, 8'h10, 3'd4, 32'h0,         32'h0, 8'd7},
    '{1'b0, 8'h20, 3'd4, 32'hFFFF_FFFF, 32'h0, 8'd2},          // R2 unmapped
    '{1'b1, 8'h20, 3'd4, 32'h0,         32'h0, 8'd2},
    '{1'b1, 8'h00, 3'd4, 32'h0,         32'h0000_0005, 8'd2}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 8'h0; bus_size = 3'd4; bus_wdata = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_size = s; bus_wdata = d;
    @(posedge clk); #1; idle();
  endtask

  task automatic rdchk(input logic [7:0] a, input logic [2:0] s,
                       input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a; bus_size = s;
    #1 check(bus_rdata == e, tag, 64'(bus_rdata), 64'(e));
    @(posedge clk); #1; idle();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  logic [NP*64-1:0] rst_img;

  initial begin
    for (int n = 0; n < NP; n++) rst_img[64*n +: 64] = 64'h0000_0000_0001_0000;
    idle();
    rirr_set = '0; rirr_clr = '0;
    do_reset();

    // R8: reset state
    @(negedge clk);
    check(entries_o == rst_img, "R8 entries after reset", entries_o[63:0], rst_img[63:0]);
    check(tbl_chg_o == 1'b0, "R8 pulse low after reset", 64'(tbl_chg_o), 64'h0);
    rdchk(8'h00, 3'd4, 32'h0, "R8 select zero after reset");

    // Table walk
    for (int v = 0; v < NV; v++) begin
      if (VECS[v].is_rd) begin
        rdchk(VECS[v].addr, VECS[v].size, VECS[v].exp,
              $sformatf("R%0d vector %0d", VECS[v].req, v));
      end else begin
        wr(VECS[v].addr, VECS[v].size, VECS[v].data);
      end
    end

    // R6: entries_o placement of entry 0 and entry 23
    @(negedge clk);
    check(entries_o[63:0] == 64'hDEAD_BEEF_0000_0031, "R6 entry0 on entries_o",
          entries_o[63:0], 64'hDEAD_BEEF_0000_0031);
    check(entries_o[64*23 +: 64] == 64'h1200_0000_0001_0000, "R6 entry23 on entries_o",
          entries_o[64*23 +: 64], 64'h1200_0000_0001_0000);

    // R9: pulse after an entry write, exactly one cycle
    wr(8'h00, 3'd4, 32'h0000_001A);            // entry 5 low
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h10; bus_size = 3'd4; bus_wdata = 32'h0000_0055;
    @(posedge clk); #1; idle();
    @(negedge clk);
    check(tbl_chg_o == 1'b1, "R9 pulse after entry write", 64'(tbl_chg_o), 64'h1);
    @(negedge clk);
    check(tbl_chg_o == 1'b0, "R9 pulse lasts one cycle", 64'(tbl_chg_o), 64'h0);
    wr(8'h10, 3'd2, 32'h0000_0066);            // wrong size: no pulse
    #1 check(tbl_chg_o == 1'b0, "R9 no pulse on sized-out write", 64'(tbl_chg_o), 64'h0);
    wr(8'h00, 3'd4, 32'h0000_0000);
    wr(8'h10, 3'd4, 32'h7700_0000);            // identifier write: no pulse
    #1 check(tbl_chg_o == 1'b0, "R9 no pulse on id write", 64'(tbl_chg_o), 64'h0);

    // R10: remote-IRR strobes on entry 3 (indices 0x16/0x17)
    @(negedge clk); rirr_set[3] = 1'b1;
    @(posedge clk); #1 rirr_set = '0;
    @(negedge clk);
    check(entries_o[64*3+14] == 1'b1, "R10 set strobe", 64'(entries_o[64*3+14]), 64'h1);
    wr(8'h00, 3'd4, 32'h0000_0016);
    rdchk(8'h10, 3'd4, 32'h0001_4000, "R10 window shows remote bit");
    wr(8'h10, 3'd4, 32'h0000_0000);
    rdchk(8'h10, 3'd4, 32'h0000_4000, "R10 software cannot clear bit 14");
    @(negedge clk); rirr_clr[3] = 1'b1;
    @(posedge clk); #1 rirr_clr = '0;
    rdchk(8'h10, 3'd4, 32'h0000_0000, "R10 clear strobe");
    @(negedge clk); rirr_set[3] = 1'b1; rirr_clr[3] = 1'b1;
    @(posedge clk); #1 begin rirr_set = '0; rirr_clr = '0; end
    rdchk(8'h10, 3'd4, 32'h0000_4000, "R10 set wins over clear");
    check(entries_o[64*4+14] == 1'b0, "R10 neighbour untouched",
          64'(entries_o[64*4+14]), 64'h0);

    // R8: reset mid-run restores everything
    do_reset();
    @(negedge clk);
    check(entries_o == rst_img, "R8 entries after second reset", entries_o[255:192], rst_img[255:192]);
    rdchk(8'h00, 3'd4, 32'h0, "R8 select after second reset");
    rdchk(8'h10, 3'd4, 32'h0, "R8 id after second reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule